// File: doc/BRIEF.md
# Register-Pair ALU with Flag-Register Writeback

This block performs the register-to-register operation group of a small 8-bit virtual-machine instruction set. Each request carries a 4-bit sub-opcode, the destination register index `x`, and two operand bytes: the current contents of the destination register (`opa`) and of the source register (`opb`). The block returns a new value for the destination and a value for the flag register, which is register 15 of the general register file. It also returns a write strobe for each of the two. Carry, borrow and shifted-out bits are delivered as 0/1 values through that general register. There is no dedicated status bit.

The results come from a combinational core. A thin output stage registers them, so every answer appears exactly one clock after the request. Sub-opcodes outside the supported nine raise an illegal-operation output and suppress both writes. When the destination itself is the flag register, the flag write wins over the result write. This follows from the order in which the two writes are applied.

Top module: `pairop_alu`

## Requirements
- R1: After reset, and until the first request, `out_valid`, `we_x`, `we_f`, `op_illegal`, `res_x` and `res_f` are all zero.
- R2: Sub-opcodes 0, 1, 2 and 3 produce opb, opa|opb, opa&opb and opa^opb respectively, assert `we_x`, and keep `we_f` low (the flag register is untouched).
- R3: Sub-opcode 4 produces (opa+opb) mod 256, asserts `we_f`, and sets `res_f` to 1 when opa+opb > 255, otherwise 0.
- R4: Sub-opcode 5 produces (opa-opb) mod 256 and sets `res_f` to 1 only when opa is strictly greater than opb (equal operands give 0).
- R5: Sub-opcode 7 produces (opb-opa) mod 256 and sets `res_f` to 1 only when opb is strictly greater than opa.
- R6: Sub-opcode 6 produces opa shifted right by one and sets `res_f` to bit 0 of opa.
- R7: Sub-opcode 14 (hex E) produces (opa shifted left by one) mod 256 and sets `res_f` to bit 7 of opa.
- R8: Sub-opcodes 8 to 13 and 15 assert `op_illegal` with `we_x` and `we_f` both low.
- R9: When `x_idx` is 15 and the operation writes the flag (sub-opcodes 4, 5, 6, 7, 14), `we_x` is low and `we_f` is high, so the flag register ends holding the flag value. For sub-opcodes 0 to 3, `x_idx` 15 still gives `we_x` high.
- R10: Outputs appear on the clock edge that samples `in_valid` high. A cycle with `in_valid` low yields `out_valid`, `we_x`, `we_f` and `op_illegal` all low on the next edge.
- R11: `res_f` is always 0 or 1, and it is 0 for sub-opcodes 0 to 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Request present this cycle |
| sub_op | input | 4 | Operation code within the group |
| x_idx | input | 4 | Destination register index |
| opa | input | 8 | Current value of the destination register |
| opb | input | 8 | Value of the source register |
| out_valid | output | 1 | Registered result present |
| res_x | output | 8 | New destination value |
| res_f | output | 8 | New flag-register value (0 or 1) |
| we_x | output | 1 | Write strobe for the destination register |
| we_f | output | 1 | Write strobe for the flag register |
| op_illegal | output | 1 | Unsupported sub-opcode seen |

## Verification
A decode fault shows as the wrong strobe pair or a raised `op_illegal` on the very next edge after the request. A faulty arithmetic function shows as a wrong `res_x` or `res_f` at that same edge. The equal-operand subtract cases, the 255+1 carry and both extreme shift bits separate a strict comparison from a non-strict one and bit 0 from bit 7. A fault in the write arbiter only shows when index 15 meets a flag-writing operation, so that pairing is exercised for every flag-writing code.

// File: rtl/pairalu_pkg.sv
package pairalu_pkg;

  typedef enum logic [3:0] {
    SOP_MOV  = 4'h0,
    SOP_OR   = 4'h1,
    SOP_AND  = 4'h2,
    SOP_XOR  = 4'h3,
    SOP_ADD  = 4'h4,
    SOP_SUB  = 4'h5,
    SOP_SHR  = 4'h6,
    SOP_RSUB = 4'h7,
    SOP_SHL  = 4'hE,
    SOP_BAD  = 4'hF
  } subop_e;

  typedef struct packed {
    logic legal;
    logic writes_flag;
  } dec_info_t;

endpackage

// File: rtl/pairalu_decode.sv
module pairalu_decode
  import pairalu_pkg::*;
(
  input  logic [3:0] sub_op,
  output subop_e     op,
  output dec_info_t  info
);

  always_comb begin
    op               = SOP_BAD;
    info.legal       = 1'b1;
    info.writes_flag = 1'b0;
    case (sub_op)
      4'h0: op = SOP_MOV;
      4'h1: op = SOP_OR;
      4'h2: op = SOP_AND;
      4'h3: op = SOP_XOR;
      4'h4: begin op = SOP_ADD;  info.writes_flag = 1'b1; end
      4'h5: begin op = SOP_SUB;  info.writes_flag = 1'b1; end
      4'h6: begin op = SOP_SHR;  info.writes_flag = 1'b1; end
      4'h7: begin op = SOP_RSUB; info.writes_flag = 1'b1; end
      4'hE: begin op = SOP_SHL;  info.writes_flag = 1'b1; end
      default: begin
        op         = SOP_BAD;
        info.legal = 1'b0;
      end
    endcase
  end

endmodule

// File: rtl/pairalu_core.sv
module pairalu_core
  import pairalu_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  subop_e            op,
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  output logic [DATA_W-1:0] result,
  output logic              flag_bit,
  output logic              add_carry,
  output logic              sub_gt,
  output logic              rsub_gt
);

  typedef logic [DATA_W-1:0] word_t;

  // sum with carry out in the top bit
  function automatic logic [DATA_W:0] f_add(input word_t p, input word_t q);
    return {1'b0, p} + {1'b0, q};
  endfunction

  // difference modulo 2^DATA_W
  function automatic word_t f_diff(input word_t p, input word_t q);
    return p - q;
  endfunction

  function automatic logic f_gt(input word_t p, input word_t q);
    return p > q;
  endfunction

  function automatic word_t f_shr(input word_t p);
    return p >> 1;
  endfunction

  function automatic word_t f_shl(input word_t p);
    return p << 1;
  endfunction

  logic [DATA_W:0] sum_w;

  assign sum_w     = f_add(a, b);
  assign add_carry = sum_w[DATA_W];
  assign sub_gt    = f_gt(a, b);
  assign rsub_gt   = f_gt(b, a);

  always_comb begin
    result   = '0;
    flag_bit = 1'b0;
    case (op)
      SOP_MOV:  result = b;
      SOP_OR:   result = a | b;
      SOP_AND:  result = a & b;
      SOP_XOR:  result = a ^ b;
      SOP_ADD:  begin result = sum_w[DATA_W-1:0]; flag_bit = add_carry; end
      SOP_SUB:  begin result = f_diff(a, b);      flag_bit = sub_gt;    end
      SOP_RSUB: begin result = f_diff(b, a);      flag_bit = rsub_gt;   end
      SOP_SHR:  begin result = f_shr(a);          flag_bit = a[0];      end
      SOP_SHL:  begin result = f_shl(a);          flag_bit = a[DATA_W-1]; end
      default: begin
        result   = '0;
        flag_bit = 1'b0;
      end
    endcase
  end

endmodule

// File: rtl/pairalu_wrsel.sv
module pairalu_wrsel
  import pairalu_pkg::*;
#(
  parameter int unsigned IDX_W = 4
) (
  input  logic             valid,
  input  dec_info_t        info,
  input  logic [IDX_W-1:0] x_idx,
  output logic             wr_x,
  output logic             wr_f,
  output logic             vf_collide
);

  localparam logic [IDX_W-1:0] FLAG_IDX = {IDX_W{1'b1}};

  logic x_is_flag;

  assign x_is_flag  = (x_idx == FLAG_IDX);
  assign wr_f       = valid & info.legal & info.writes_flag;
  // the flag write lands last, so the result write is dropped
  assign vf_collide = wr_f & x_is_flag;
  assign wr_x       = valid & info.legal & ~vf_collide;

endmodule

// File: rtl/pairop_alu.sv
module pairop_alu
  import pairalu_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned IDX_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [3:0]        sub_op,
  input  logic [IDX_W-1:0]  x_idx,
  input  logic [DATA_W-1:0] opa,
  input  logic [DATA_W-1:0] opb,
  output logic              out_valid,
  output logic [DATA_W-1:0] res_x,
  output logic [DATA_W-1:0] res_f,
  output logic              we_x,
  output logic              we_f,
  output logic              op_illegal
);

  subop_e            op_w;
  dec_info_t         info_w;
  logic [DATA_W-1:0] core_res;
  logic              core_flag;
  logic              add_carry;
  logic              sub_gt;
  logic              rsub_gt;
  logic              wr_x_d;
  logic              wr_f_d;
  logic              vf_collide;
  logic              illegal_d;

  pairalu_decode u_dec (
    .sub_op (sub_op),
    .op     (op_w),
    .info   (info_w)
  );

  pairalu_core #(.DATA_W(DATA_W)) u_core (
    .op        (op_w),
    .a         (opa),
    .b         (opb),
    .result    (core_res),
    .flag_bit  (core_flag),
    .add_carry (add_carry),
    .sub_gt    (sub_gt),
    .rsub_gt   (rsub_gt)
  );

  pairalu_wrsel #(.IDX_W(IDX_W)) u_wrsel (
    .valid      (in_valid),
    .info       (info_w),
    .x_idx      (x_idx),
    .wr_x       (wr_x_d),
    .wr_f       (wr_f_d),
    .vf_collide (vf_collide)
  );

  assign illegal_d = in_valid & ~info_w.legal;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      res_x      <= '0;
      res_f      <= '0;
      we_x       <= 1'b0;
      we_f       <= 1'b0;
      op_illegal <= 1'b0;
    end else begin
      out_valid  <= in_valid;
      we_x       <= wr_x_d;
      we_f       <= wr_f_d;
      op_illegal <= illegal_d;
      if (in_valid) begin
        res_x <= core_res;
        res_f <= {{(DATA_W-1){1'b0}}, core_flag};
      end
    end
  end

endmodule

// File: rtl/pairop_alu_chk.sv
module pairop_alu_chk #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned IDX_W  = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic [3:0]        sub_op,
  input logic [IDX_W-1:0]  x_idx,
  input logic [DATA_W-1:0] opa,
  input logic [DATA_W-1:0] opb,
  input logic              out_valid,
  input logic [DATA_W-1:0] res_x,
  input logic [DATA_W-1:0] res_f,
  input logic              we_x,
  input logic              we_f,
  input logic              op_illegal,
  input logic              add_carry,
  input logic              sub_gt,
  input logic              vf_collide
);

  p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> (!out_valid && !we_x && !we_f && !op_illegal));

  p_illegal_silent_r8: assert property (@(posedge clk) disable iff (!rst_n)
    op_illegal |-> (!we_x && !we_f));

  p_logic_no_flag_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && sub_op <= 4'h3) |=> (we_x && !we_f && res_f == '0));

  p_add_carry_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && sub_op == 4'h4) |=> (we_f && res_f[0] == $past(add_carry) && (res_f >> 1) == '0));

  p_sub_strict_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && sub_op == 4'h5) |=> (res_f[0] == $past(sub_gt) && res_x == $past(opa - opb)));

  p_shr_bit0_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && sub_op == 4'h6) |=> (res_f[0] == $past(opa[0]) && res_x == ($past(opa) >> 1)));

  p_vf_priority_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && vf_collide) |=> (we_f && !we_x));

  p_collide_index_r9: assert property (@(posedge clk) disable iff (!rst_n)
    vf_collide |-> (x_idx == {IDX_W{1'b1}}));

  p_flag_binary_r11: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> ((res_f >> 1) == '0));

  p_valid_follows_r10: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  p_mov_copies_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && sub_op == 4'h0) |=> (res_x == $past(opb)));

endmodule

bind pairop_alu pairop_alu_chk #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .in_valid   (in_valid),
  .sub_op     (sub_op),
  .x_idx      (x_idx),
  .opa        (opa),
  .opb        (opb),
  .out_valid  (out_valid),
  .res_x      (res_x),
  .res_f      (res_f),
  .we_x       (we_x),
  .we_f       (we_f),
  .op_illegal (op_illegal),
  .add_carry  (add_carry),
  .sub_gt     (sub_gt),
  .vf_collide (vf_collide)
);

// File: tb/pairop_alu_test.sv
module pairop_alu_test;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       in_valid = 1'b0;
  logic [3:0] sub_op = '0;
  logic [3:0] x_idx = '0;
  logic [7:0] opa = '0;
  logic [7:0] opb = '0;
  logic       out_valid;
  logic [7:0] res_x;
  logic [7:0] res_f;
  logic       we_x;
  logic       we_f;
  logic       op_illegal;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #4 clk = ~clk;

  pairop_alu uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .sub_op(sub_op),
    .x_idx(x_idx), .opa(opa), .opb(opb), .out_valid(out_valid),
    .res_x(res_x), .res_f(res_f), .we_x(we_x), .we_f(we_f),
    .op_illegal(op_illegal)
  );

  task automatic check(input string req, input string what, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // independent model written with integer arithmetic
  task automatic model(input int op, input int x, input int a, input int b,
                       output int r, output int f, output int wx, output int wf,
                       output int ill);
    r = 0; f = 0; wx = 0; wf = 0; ill = 0;
    case (op)
      0: begin r = b; wx = 1; end
      1: begin r = a | b; wx = 1; end
      2: begin r = a & b; wx = 1; end
      3: begin r = a ^ b; wx = 1; end
      4: begin r = (a + b) % 256; f = (a + b >= 256) ? 1 : 0; wf = 1; wx = 1; end
      5: begin r = (a - b + 256) % 256; f = (a > b) ? 1 : 0; wf = 1; wx = 1; end
      6: begin r = a / 2; f = a % 2; wf = 1; wx = 1; end
      7: begin r = (b - a + 256) % 256; f = (b > a) ? 1 : 0; wf = 1; wx = 1; end
      14: begin r = (a * 2) % 256; f = (a >= 128) ? 1 : 0; wf = 1; wx = 1; end
      default: ill = 1;
    endcase
    if (wf == 1 && x == 15) wx = 0;
  endtask

  // one request, then sample at the negedge after the capturing edge
  task automatic run_op(input string req, input int op, input int x, input int a, input int b);
    int r, f, wx, wf, ill;
    @(negedge clk);
    in_valid = 1'b1; sub_op = op[3:0]; x_idx = x[3:0]; opa = a[7:0]; opb = b[7:0];
    @(negedge clk);
    in_valid = 1'b0;
    model(op, x, a, b, r, f, wx, wf, ill);
    check(req, "out_valid", int'(out_valid), 1);
    check(req, "op_illegal", int'(op_illegal), ill);
    check(req, "we_x", int'(we_x), wx);
    check(req, "we_f", int'(we_f), wf);
    if (ill == 0) begin
      check(req, "res_x", int'(res_x), r);
      check(req, "res_f", int'(res_f), f);
    end
  endtask

  task automatic t_reset_r1();
    check("R1", "out_valid", int'(out_valid), 0);
    check("R1", "we_x", int'(we_x), 0);
    check("R1", "we_f", int'(we_f), 0);
    check("R1", "op_illegal", int'(op_illegal), 0);
    check("R1", "res_x", int'(res_x), 0);
    check("R1", "res_f", int'(res_f), 0);
  endtask

  task automatic t_logic_r2();
    run_op("R2", 0, 3, 8'h12, 8'hA5);
    run_op("R2", 1, 4, 8'hF0, 8'h0F);
    run_op("R2", 2, 5, 8'hCC, 8'hAA);
    run_op("R2", 3, 6, 8'hFF, 8'h5A);
    run_op("R2", 0, 15, 8'h01, 8'h77);  // logic op on index 15 still writes x
  endtask

  task automatic t_add_r3();
    run_op("R3", 4, 1, 10, 20);
    run_op("R3", 4, 1, 255, 1);
    run_op("R3", 4, 1, 128, 127);
    run_op("R3", 4, 1, 200, 200);
  endtask

  task automatic t_sub_r4();
    run_op("R4", 5, 2, 50, 20);
    run_op("R4", 5, 2, 20, 50);
    run_op("R4", 5, 2, 77, 77);   // equal gives flag 0
    run_op("R4", 5, 2, 0, 255);
  endtask

  task automatic t_rsub_r5();
    run_op("R5", 7, 2, 20, 50);
    run_op("R5", 7, 2, 50, 20);
    run_op("R5", 7, 2, 99, 99);
  endtask

  task automatic t_shr_r6();
    run_op("R6", 6, 7, 8'h81, 0);
    run_op("R6", 6, 7, 8'h80, 0);
    run_op("R6", 6, 7, 8'h01, 0);
  endtask

  task automatic t_shl_r7();
    run_op("R7", 14, 8, 8'h81, 0);
    run_op("R7", 14, 8, 8'h7F, 0);
    run_op("R7", 14, 8, 8'h40, 0);
  endtask

  task automatic t_illegal_r8();
    for (int c = 8; c <= 13; c++) run_op("R8", c, 3, 8'h55, 8'h33);
    run_op("R8", 15, 3, 8'h55, 8'h33);
    run_op("R8", 9, 15, 8'hFF, 8'hFF);
  endtask

  task automatic t_vf_priority_r9();
    run_op("R9", 4, 15, 255, 2);
    run_op("R9", 5, 15, 3, 9);
    run_op("R9", 6, 15, 8'h03, 0);
    run_op("R9", 7, 15, 1, 200);
    run_op("R9", 14, 15, 8'h80, 0);
    run_op("R9", 3, 15, 8'h0F, 8'hF0);
  endtask

  task automatic t_idle_r10();
    run_op("R10", 4, 1, 250, 10);
    @(negedge clk);   // in_valid low since the previous sample
    check("R10", "out_valid idle", int'(out_valid), 0);
    check("R10", "we_x idle", int'(we_x), 0);
    check("R10", "we_f idle", int'(we_f), 0);
    check("R10", "op_illegal idle", int'(op_illegal), 0);
  endtask

  task automatic t_flag_binary_r11();
    run_op("R11", 2, 0, 8'hFF, 8'hFF);
    check("R11", "res_f logic", int'(res_f), 0);
    run_op("R11", 4, 0, 8'hFF, 8'hFF);
    check("R11", "res_f upper bits", int'(res_f >> 1), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset_r1();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset_r1();
    t_logic_r2();
    t_add_r3();
    t_sub_r4();
    t_rsub_r5();
    t_shr_r6();
    t_shl_r7();
    t_illegal_r8();
    t_vf_priority_r9();
    t_idle_r10();
    t_flag_binary_r11();
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

endmodule